// File: doc/BRIEF.md
# Shared-Level Registry With Owner Forwarding

This block is the controller of a shared second-level cache for a coherence scheme that keeps no directory. Every cached word holds one of two things: the word's value, or the ID of the first-level cache that has taken write ownership of it. A one-bit flag per word says which of the two the payload is. Because ownership is recorded in that flag, no extra directory storage is needed.

Requesters send one request at a time over a valid/ready handshake. A request can be a read, a registration (taking ownership) or a writeback (giving the value back). Each request gets exactly one response, tagged with the requester's ID. A read of an owned word is answered with a redirect that names the owner. A registration that takes a word from a previous owner also sends that owner a revoke notice. A request the block cannot serve is refused with a NACK, so the requester can retry.

The cache is direct-mapped and keeps a valid bit and a dirty bit per line. A miss fetches the line from an internal backing array after a fixed latency. Before that fetch, a dirty victim line is written back to the array. A victim line that still holds an owned word cannot be evicted.

Top module: `shreg_registry`

## Requirements
- R1: Under reset, `req_ready_o` is 1 and `rsp_valid_o` and `rvk_valid_o` are 0. Out of reset, each backing word at word address a holds MEM_BASE + a, which is 0xA000 + a by default.
- R2: A request is accepted on a rising edge where `req_valid_i` and `req_ready_o` are both high. `req_ready_o` then stays low until the response is issued. Each request produces one `rsp_valid_o` pulse that lasts one cycle, and `rsp_dst_o` in that pulse equals the requester's `req_src_i`.
- R3: A read (op 0) of a word that is not owned returns kind DATA (0) with the stored value in `rsp_data_o`.
- R4: A registration (op 1) from requester N returns kind ACK (2). After that, any read of the word returns kind REDIRECT (1), with `rsp_data_o` equal to N zero-extended.
- R5: If a registration finds the word owned by a different requester M, a one-cycle `rvk_valid_o` pulse goes out in the same cycle as the ACK, with `rvk_dst_o` = M and `rvk_addr_o` = the word address. A registration by the current owner sends no revoke.
- R6: A writeback (op 2) from the current owner returns ACK, stores `req_data_i` as the word's value and clears ownership. A later read returns DATA with that value. The line becomes dirty.
- R7: A writeback from a requester that is not the owner, or to a word that is not owned, returns NACK (3) and leaves the word unchanged.
- R8: Op code 3 is reserved and is always answered with NACK.
- R9: The response appears this many rising edges after the acceptance edge:
  - a hit: 1;
  - a miss whose victim slot is empty or clean: FILL_LAT+2;
  - a miss whose victim is dirty: FILL_LAT+3.
  Address bits [1:0] select the word, [3:2] the line slot and [5:4] the tag (default widths).
- R10: A miss whose victim line holds any owned word is answered with NACK after 1 edge. The resident line stays in place, with its ownership unchanged.
- R11: A dirty line that is evicted is written to the backing array. Fetching that line again later returns the written-back values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle, able to take a request |
| req_op_i | input | 2 | 0 read, 1 register, 2 writeback, 3 reserved |
| req_src_i | input | ID_W | Requesting cache ID |
| req_addr_i | input | ADDR_W | Word address |
| req_data_i | input | DATA_W | Writeback value |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_kind_o | output | 2 | 0 DATA, 1 REDIRECT, 2 ACK, 3 NACK |
| rsp_dst_o | output | ID_W | Requester the response is for |
| rsp_data_o | output | DATA_W | Word value, or owner ID for REDIRECT |
| rvk_valid_o | output | 1 | Revoke notice pulse |
| rvk_dst_o | output | ID_W | Previous owner being revoked |
| rvk_addr_o | output | ADDR_W | Word whose ownership moved |

## Verification
The bench checks each corner case below and what a broken design would do on it:
- Re-registration by the same owner. A design that compared against the wrong ID would revoke the requester itself.
- A writeback from a stale former owner. A design that skipped the owner check would overwrite the value with stale data.
- A dirty eviction followed by a refetch. A design that dropped the dirty write-back would bring back the original backing value, or respond one cycle early.
- A conflicting miss on a line pinned by ownership. A design that evicted anyway would lose the owner ID, so the later redirect would be missing.

// File: rtl/shreg_pkg.sv
package shreg_pkg;
  typedef enum logic [1:0] {
    OP_READ      = 2'd0,
    OP_REGISTER  = 2'd1,
    OP_WRITEBACK = 2'd2,
    OP_RSVD      = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    RSP_DATA     = 2'd0,
    RSP_REDIRECT = 2'd1,
    RSP_ACK      = 2'd2,
    RSP_NACK     = 2'd3
  } rsp_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOK,
    ST_EVICT,
    ST_FILL
  } st_e;
endpackage

// File: rtl/shreg_backing_mem.sv
module shreg_backing_mem #(
  parameter int MEM_LINES = 16,
  parameter int WORDS     = 4,
  parameter int DATA_W    = 16,
  parameter int MEM_BASE  = 'hA000
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [$clog2(MEM_LINES)-1:0] idx_i,
  input  logic                         wr_en_i,
  input  logic [WORDS*DATA_W-1:0]      wr_line_i,
  output logic [WORDS*DATA_W-1:0]      rd_line_o
);
  localparam int LINE_W = WORDS * DATA_W;

  logic [LINE_W-1:0] mem_q [MEM_LINES];

  // R1: reset contents are computed from the word address
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int l = 0; l < MEM_LINES; l++)
        for (int w = 0; w < WORDS; w++)
          mem_q[l][w*DATA_W +: DATA_W] <= DATA_W'(MEM_BASE + l*WORDS + w);
    end else if (wr_en_i) begin
      mem_q[idx_i] <= wr_line_i;
    end
  end

  assign rd_line_o = mem_q[idx_i];
endmodule

// File: rtl/shreg_fill_timer.sv
module shreg_fill_timer #(
  parameter int LAT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int CNT_W = $clog2(LAT + 1);

  logic [CNT_W-1:0] cnt_q;

  assign done_o = run_i && (cnt_q == CNT_W'(LAT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || done_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + CNT_W'(1);
  end

  a_r9_fill_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(LAT));
  a_r9_done_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (cnt_q == '0));
endmodule

// File: rtl/shreg_line_store.sv
module shreg_line_store #(
  parameter int LINES  = 4,
  parameter int WORDS  = 4,
  parameter int DATA_W = 16,
  parameter int TAG_W  = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [$clog2(LINES)-1:0] idx_i,
  input  logic [$clog2(WORDS)-1:0] word_i,
  output logic                     valid_o,
  output logic                     dirty_o,
  output logic [TAG_W-1:0]         tag_o,
  output logic                     any_flag_o,
  output logic                     flag_o,
  output logic [DATA_W-1:0]        pay_o,
  output logic [WORDS*DATA_W-1:0]  line_o,
  input  logic                     fill_en_i,
  input  logic [TAG_W-1:0]         fill_tag_i,
  input  logic [WORDS*DATA_W-1:0]  fill_line_i,
  input  logic                     wr_en_i,
  input  logic                     wr_flag_i,
  input  logic [DATA_W-1:0]        wr_pay_i,
  input  logic                     wr_dirty_i
);
  localparam int LINE_W = WORDS * DATA_W;

  logic [LINES-1:0]  valid_q, dirty_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [WORDS-1:0]  flag_q [LINES];
  logic [LINE_W-1:0] data_q [LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
      for (int l = 0; l < LINES; l++) begin
        tag_q[l]  <= '0;
        flag_q[l] <= '0;
        data_q[l] <= '0;
      end
    end else if (fill_en_i) begin
      valid_q[idx_i] <= 1'b1;
      dirty_q[idx_i] <= 1'b0;
      tag_q[idx_i]   <= fill_tag_i;
      flag_q[idx_i]  <= '0;
      data_q[idx_i]  <= fill_line_i;
    end else if (wr_en_i) begin
      flag_q[idx_i][word_i]                       <= wr_flag_i;
      data_q[idx_i][int'(word_i)*DATA_W +: DATA_W] <= wr_pay_i;
      if (wr_dirty_i) dirty_q[idx_i] <= 1'b1;
    end
  end

  assign valid_o    = valid_q[idx_i];
  assign dirty_o    = dirty_q[idx_i];
  assign tag_o      = tag_q[idx_i];
  assign any_flag_o = |flag_q[idx_i];
  assign flag_o     = flag_q[idx_i][word_i];
  assign pay_o      = data_q[idx_i][int'(word_i)*DATA_W +: DATA_W];
  assign line_o     = data_q[idx_i];

  // R10: a line carrying an owner must never be overwritten by a fill
  a_r10_no_fill_over_owned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_en_i |-> !(valid_q[idx_i] && (|flag_q[idx_i])));
  a_r11_fill_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_en_i |=> (!dirty_q[$past(idx_i)] && flag_q[$past(idx_i)] == '0));
endmodule

// File: rtl/shreg_registry.sv
module shreg_registry
  import shreg_pkg::*;
#(
  parameter int MEM_LINES = 16,
  parameter int LINES     = 4,
  parameter int WORDS     = 4,
  parameter int DATA_W    = 16,
  parameter int ID_W      = 3,
  parameter int FILL_LAT  = 4,
  parameter int MEM_BASE  = 'hA000,
  localparam int WORD_W    = $clog2(WORDS),
  localparam int IDX_W     = $clog2(LINES),
  localparam int MEM_IDX_W = $clog2(MEM_LINES),
  localparam int TAG_W     = MEM_IDX_W - IDX_W,
  localparam int ADDR_W    = MEM_IDX_W + WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_op_i,
  input  logic [ID_W-1:0]   req_src_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_data_i,
  output logic              rsp_valid_o,
  output logic [1:0]        rsp_kind_o,
  output logic [ID_W-1:0]   rsp_dst_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              rvk_valid_o,
  output logic [ID_W-1:0]   rvk_dst_o,
  output logic [ADDR_W-1:0] rvk_addr_o
);
  localparam int LINE_W = WORDS * DATA_W;

  st_e               st_q, st_d;
  op_e               op_q;
  logic [ID_W-1:0]   src_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  logic [WORD_W-1:0] word_q;
  logic [IDX_W-1:0]  idx_q;
  logic [TAG_W-1:0]  tag_q;
  assign word_q = addr_q[WORD_W-1:0];
  assign idx_q  = addr_q[WORD_W +: IDX_W];
  assign tag_q  = addr_q[ADDR_W-1 -: TAG_W];

  logic              ls_valid, ls_dirty, ls_any_flag, ls_flag;
  logic [TAG_W-1:0]  ls_tag;
  logic [DATA_W-1:0] ls_pay;
  logic [LINE_W-1:0] ls_line, mem_line;
  logic              ls_fill_en, ls_wr_en, ls_wr_flag, ls_wr_dirty;
  logic [DATA_W-1:0] ls_wr_pay;
  logic              mem_wr, timer_run, timer_done;
  logic [MEM_IDX_W-1:0] mem_idx;

  shreg_line_store #(
    .LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W), .TAG_W(TAG_W)
  ) u_store (
    .clk_i, .rst_ni,
    .idx_i(idx_q), .word_i(word_q),
    .valid_o(ls_valid), .dirty_o(ls_dirty), .tag_o(ls_tag),
    .any_flag_o(ls_any_flag), .flag_o(ls_flag), .pay_o(ls_pay), .line_o(ls_line),
    .fill_en_i(ls_fill_en), .fill_tag_i(tag_q), .fill_line_i(mem_line),
    .wr_en_i(ls_wr_en), .wr_flag_i(ls_wr_flag), .wr_pay_i(ls_wr_pay),
    .wr_dirty_i(ls_wr_dirty)
  );

  assign mem_idx = (st_q == ST_EVICT) ? {ls_tag, idx_q} : {tag_q, idx_q};

  shreg_backing_mem #(
    .MEM_LINES(MEM_LINES), .WORDS(WORDS), .DATA_W(DATA_W), .MEM_BASE(MEM_BASE)
  ) u_mem (
    .clk_i, .rst_ni,
    .idx_i(mem_idx), .wr_en_i(mem_wr), .wr_line_i(ls_line), .rd_line_o(mem_line)
  );

  shreg_fill_timer #(.LAT(FILL_LAT)) u_timer (
    .clk_i, .rst_ni, .run_i(timer_run), .done_o(timer_done)
  );

  logic            hit;
  logic [ID_W-1:0] owner;
  assign hit   = ls_valid && (ls_tag == tag_q);
  assign owner = ls_pay[ID_W-1:0];

  logic              rsp_fire, rvk_fire;
  rsp_e              rsp_kind;
  logic [DATA_W-1:0] rsp_data;

  always_comb begin
    st_d        = st_q;
    rsp_fire    = 1'b0;
    rsp_kind    = RSP_NACK;
    rsp_data    = '0;
    rvk_fire    = 1'b0;
    ls_wr_en    = 1'b0;
    ls_wr_flag  = 1'b0;
    ls_wr_pay   = '0;
    ls_wr_dirty = 1'b0;
    ls_fill_en  = 1'b0;
    mem_wr      = 1'b0;
    timer_run   = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req_valid_i) st_d = ST_LOOK;
      ST_LOOK: begin
        if (op_q == OP_RSVD) begin
          rsp_fire = 1'b1;
        end else if (hit) begin
          rsp_fire = 1'b1;
          unique case (op_q)
            OP_READ: begin
              rsp_kind = ls_flag ? RSP_REDIRECT : RSP_DATA;
              rsp_data = ls_pay;
            end
            OP_REGISTER: begin
              ls_wr_en   = 1'b1;
              ls_wr_flag = 1'b1;
              ls_wr_pay  = DATA_W'(src_q);
              rsp_kind   = RSP_ACK;
              rvk_fire   = ls_flag && (owner != src_q);
            end
            OP_WRITEBACK: begin
              if (ls_flag && owner == src_q) begin
                ls_wr_en    = 1'b1;
                ls_wr_pay   = data_q;
                ls_wr_dirty = 1'b1;
                rsp_kind    = RSP_ACK;
              end
            end
            default: ;
          endcase
        end else if (ls_valid && ls_any_flag) begin
          rsp_fire = 1'b1;  // victim pinned by an owner
        end else if (ls_valid && ls_dirty) begin
          st_d = ST_EVICT;
        end else begin
          st_d = ST_FILL;
        end
        if (rsp_fire) st_d = ST_IDLE;
      end
      ST_EVICT: begin
        mem_wr = 1'b1;
        st_d   = ST_FILL;
      end
      ST_FILL: begin
        timer_run = 1'b1;
        if (timer_done) begin
          ls_fill_en = 1'b1;
          st_d       = ST_LOOK;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign req_ready_o = (st_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      op_q        <= OP_READ;
      src_q       <= '0;
      addr_q      <= '0;
      data_q      <= '0;
      rsp_valid_o <= 1'b0;
      rsp_kind_o  <= '0;
      rsp_dst_o   <= '0;
      rsp_data_o  <= '0;
      rvk_valid_o <= 1'b0;
      rvk_dst_o   <= '0;
      rvk_addr_o  <= '0;
    end else begin
      st_q <= st_d;
      if (req_valid_i && req_ready_o) begin
        op_q   <= op_e'(req_op_i);
        src_q  <= req_src_i;
        addr_q <= req_addr_i;
        data_q <= req_data_i;
      end
      rsp_valid_o <= rsp_fire;
      rvk_valid_o <= rvk_fire;
      if (rsp_fire) begin
        rsp_kind_o <= rsp_kind;
        rsp_dst_o  <= src_q;
        rsp_data_o <= rsp_data;
      end
      if (rvk_fire) begin
        rvk_dst_o  <= owner;
        rvk_addr_o <= addr_q;
      end
    end
  end

  a_r2_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
  a_r2_rsp_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  a_r2_idle_with_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> req_ready_o);
  a_r5_rvk_with_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvk_valid_o |-> (rsp_valid_o && rsp_kind_o == RSP_ACK));
  a_r5_rvk_not_self: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvk_valid_o |-> (rvk_dst_o != rsp_dst_o));
  a_r4_redirect_id_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_kind_o == RSP_REDIRECT) |-> ((rsp_data_o >> ID_W) == '0));
endmodule

// File: tb/tb_shreg_registry.sv
module tb_shreg_registry;
  localparam int CLK_PERIOD = 10;
  localparam int FL         = 4;
  localparam int ID_W       = 3;
  localparam int DATA_W     = 16;
  localparam int ADDR_W     = 6;
  localparam int K_DATA = 0, K_REDIR = 1, K_ACK = 2, K_NACK = 3;
  localparam int OP_RD = 0, OP_REG = 1, OP_WB = 2, OP_RES = 3;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid_i = 1'b0;
  logic              req_ready_o;
  logic [1:0]        req_op_i = '0;
  logic [ID_W-1:0]   req_src_i = '0;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic [DATA_W-1:0] req_data_i = '0;
  logic              rsp_valid_o;
  logic [1:0]        rsp_kind_o;
  logic [ID_W-1:0]   rsp_dst_o;
  logic [DATA_W-1:0] rsp_data_o;
  logic              rvk_valid_o;
  logic [ID_W-1:0]   rvk_dst_o;
  logic [ADDR_W-1:0] rvk_addr_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  shreg_registry #(.FILL_LAT(FL)) dut (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int r_kind, r_dst, r_data, r_rvk, r_rvk_dst, r_rvk_addr, r_lat;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic xfer(int op, int src, int addr, int data);
    int n;
    @(negedge clk_i);
    while (!req_ready_o) @(negedge clk_i);
    req_valid_i = 1'b1;
    req_op_i    = 2'(op);
    req_src_i   = ID_W'(src);
    req_addr_i  = ADDR_W'(addr);
    req_data_i  = DATA_W'(data);
    @(posedge clk_i);
    n = 0;
    while (n < 64) begin
      @(negedge clk_i);
      req_valid_i = 1'b0;
      n++;
      if (rsp_valid_o) break;
      if (req_ready_o) chk("R2 ready low while busy", 1, 0);
    end
    r_lat      = n - 1;
    r_kind     = int'(rsp_kind_o);
    r_dst      = int'(rsp_dst_o);
    r_data     = int'(rsp_data_o);
    r_rvk      = int'(rvk_valid_o);
    r_rvk_dst  = int'(rvk_dst_o);
    r_rvk_addr = int'(rvk_addr_o);
    chk("R2 response dst", r_dst, src);
    @(negedge clk_i);
    chk("R2 response single pulse", int'(rsp_valid_o), 0);
    chk("R5 revoke pulse ends", int'(rvk_valid_o), 0);
  endtask

  task automatic t_reset;
    chk("R1 ready in reset", int'(req_ready_o), 1);
    chk("R1 rsp idle in reset", int'(rsp_valid_o), 0);
    chk("R1 rvk idle in reset", int'(rvk_valid_o), 0);
  endtask

  task automatic t_first_reads;
    xfer(OP_RD, 1, 0, 0);
    chk("R1 backing content kind", r_kind, K_DATA);
    chk("R1 backing content", r_data, 'hA000);
    chk("R9 clean miss latency", r_lat, FL + 2);
    xfer(OP_RD, 4, 1, 0);
    chk("R3 read kind", r_kind, K_DATA);
    chk("R3 read value", r_data, 'hA001);
    chk("R9 hit latency", r_lat, 1);
  endtask

  task automatic t_register;
    xfer(OP_REG, 2, 1, 0);
    chk("R4 register ack", r_kind, K_ACK);
    chk("R5 no revoke on free word", r_rvk, 0);
    xfer(OP_RD, 5, 1, 0);
    chk("R4 redirect kind", r_kind, K_REDIR);
    chk("R4 redirect owner", r_data, 2);
  endtask

  task automatic t_revoke;
    xfer(OP_REG, 3, 1, 0);
    chk("R5 takeover ack", r_kind, K_ACK);
    chk("R5 revoke sent", r_rvk, 1);
    chk("R5 revoke dst", r_rvk_dst, 2);
    chk("R5 revoke addr", r_rvk_addr, 1);
    xfer(OP_REG, 3, 1, 0);
    chk("R5 re-register ack", r_kind, K_ACK);
    chk("R5 no self revoke", r_rvk, 0);
  endtask

  task automatic t_bad_writeback;
    xfer(OP_WB, 2, 1, 'h1234);
    chk("R7 stale owner nack", r_kind, K_NACK);
    xfer(OP_RD, 6, 1, 0);
    chk("R7 owner kept kind", r_kind, K_REDIR);
    chk("R7 owner kept id", r_data, 3);
    xfer(OP_WB, 1, 0, 'h5555);
    chk("R7 unowned wb nack", r_kind, K_NACK);
    xfer(OP_RD, 1, 0, 0);
    chk("R7 unowned word unchanged", r_data, 'hA000);
  endtask

  task automatic t_good_writeback;
    xfer(OP_WB, 3, 1, 'hBEEF);
    chk("R6 owner wb ack", r_kind, K_ACK);
    xfer(OP_RD, 4, 1, 0);
    chk("R6 released kind", r_kind, K_DATA);
    chk("R6 released value", r_data, 'hBEEF);
  endtask

  task automatic t_reserved;
    xfer(OP_RES, 7, 2, 0);
    chk("R8 reserved op nack", r_kind, K_NACK);
    chk("R8 reserved op dst", r_dst, 7);
  endtask

  task automatic t_dirty_evict;
    xfer(OP_RD, 1, 16, 0);
    chk("R11 conflict read value", r_data, 'hA010);
    chk("R9 dirty miss latency", r_lat, FL + 3);
    xfer(OP_RD, 1, 1, 0);
    chk("R11 written-back value", r_data, 'hBEEF);
    chk("R9 clean victim latency", r_lat, FL + 2);
  endtask

  task automatic t_pinned;
    xfer(OP_REG, 4, 8, 0);
    chk("R4 register after fill", r_kind, K_ACK);
    chk("R9 register miss latency", r_lat, FL + 2);
    xfer(OP_RD, 1, 'h18, 0);
    chk("R10 pinned victim nack", r_kind, K_NACK);
    chk("R10 nack latency", r_lat, 1);
    xfer(OP_RD, 6, 8, 0);
    chk("R10 line stays resident", r_lat, 1);
    chk("R10 owner kept", r_data, 4);
    chk("R10 redirect kind", r_kind, K_REDIR);
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_first_reads();
    t_register();
    t_revoke();
    t_bad_writeback();
    t_good_writeback();
    t_reserved();
    t_dirty_evict();
    t_pinned();
    done = 1;
    summary();
    $finish;
  end
endmodule